// File: doc/BRIEF.md
# Serial Port Byte Queue with Fill Triggers and DMA Requests

This block is the byte queue that sits between a serial engine and the system bus, on either the receive or the transmit side of a port. It keeps up to sixteen bytes in arrival order. A read port shows the oldest byte at all times. The block reports how full it is and raises two request lines for a DMA controller. The single request asks for one transfer. The trigger request covers the interrupt and the burst transfer, and it fires when the fill level crosses a threshold that software picks from five fractions of the depth.

A compile-time direction parameter decides what the requests mean. On the receive side, they ask the controller to take bytes away. On the transmit side, they ask it to bring bytes in. A run-time control input cuts the usable depth to a single entry, so the queue acts as a plain double-buffered holding register. A flush input empties the queue in one cycle. A write into a full queue and a read from an empty queue are both dropped, and each one leaves a one-cycle error flag.

Top module: `byte_queue_dma`

## Requirements
- R1: Bytes leave in the order they were written. In normal mode the queue holds up to DEPTH (16) bytes, and `rd_data` always shows the oldest stored byte.
- R2: `level` counts the stored bytes and changes on the clock edge that accepts a write or a read. `empty` is high when `level` is 0. In normal mode, `full` is high when `level` equals DEPTH.
- R3: A write while `full` is high is dropped and leaves `level` unchanged. `overflow` goes high for exactly the one cycle that follows that edge.
- R4: A read while `empty` is high is dropped and leaves `level` unchanged. `underflow` goes high for exactly the one cycle that follows that edge.
- R5: While `one_entry` is 1, `full` is high whenever at least one byte is stored, so a second write is dropped as in R3.
- R6: `trig_sel` picks the threshold T as follows: 0 gives DEPTH/8, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives 3*DEPTH/4, 4 gives 7*DEPTH/8, and 5 to 7 give DEPTH/2.
- R7: For the receive direction (IS_TX=0) in normal mode, `trig_req` is high exactly when `level` >= T.
- R8: For the transmit direction (IS_TX=1) in normal mode, `trig_req` is high exactly when `level` <= T.
- R9: While `one_entry` is 1, `trig_sel` has no effect. For the receive direction, `trig_req` is high when `level` >= 1. For the transmit direction, it is high when `level` is 0.
- R10: For the receive direction, `dma_single` is high exactly when at least one byte is stored.
- R11: For the transmit direction, `dma_single` is high exactly when `full` is low.
- R12: `flush` empties the queue at the next edge and ignores any write or read in that same cycle. After `rst_n` low, the queue is empty and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the queue at the next edge |
| one_entry | input | 1 | 1 selects single-entry (holding register) mode |
| trig_sel | input | 3 | Threshold fraction select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W (8) | Byte to write |
| rd_en | input | 1 | Read (pop) strobe |
| rd_data | output | W (8) | Oldest stored byte |
| level | output | $clog2(DEPTH+1) (5) | Number of stored bytes |
| full | output | 1 | No free entry in the current mode |
| empty | output | 1 | No byte stored |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| underflow | output | 1 | One-cycle pulse after a dropped read |
| trig_req | output | 1 | Threshold hit; serves as interrupt and burst request |
| dma_single | output | 1 | Single-transfer DMA request |

## Verification
The bench runs a receive instance and a transmit instance side by side on the same stimulus. It sweeps fill levels just below, at and just above every threshold, so that an off-by-one compare or a swapped comparison direction shows up as a wrong `trig_req`. It writes past full and reads past empty, and checks that the level holds and that each flag lasts exactly one cycle. A design that let a dropped access through would corrupt `level` or the byte order, and a design with a sticky flag would still show it high a cycle later. It also switches into single-entry mode with a nonzero `trig_sel` and then flushes while a write is pending. A design that kept using the fractional threshold, or that accepted the write during the flush, would show a wrong request or a nonzero level.

// File: rtl/byte_queue_pkg.sv
package byte_queue_pkg;

  // Threshold in entries for a given selector; single-entry mode overrides it.
  function automatic int unsigned trig_thresh(input logic [2:0] sel,
                                              input int unsigned depth,
                                              input logic single,
                                              input logic is_tx);
    if (single) return is_tx ? 0 : 1;
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth / 2;
    endcase
  endfunction

  // Receive side fires at or above the mark, transmit side at or below it.
  function automatic logic trig_hit(input logic is_tx,
                                    input int unsigned fill,
                                    input int unsigned mark);
    return is_tx ? (fill <= mark) : (fill >= mark);
  endfunction

endpackage

// File: rtl/byte_queue_store.sv
module byte_queue_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
    end
  end

  assign rd_data = mem[rptr];

  // R12: a flush returns both pointers to the origin
  p_ptr_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wptr == '0 && rptr == '0));
endmodule

// File: rtl/byte_queue_level.sv
module byte_queue_level #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          one_entry,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          push,
  output logic          pop,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          overflow,
  output logic          underflow
);
  logic wr_drop, rd_drop;

  assign empty   = (level == '0);
  assign full    = one_entry ? !empty : (level == CW'(DEPTH));
  assign push    = wr_en && !full  && !flush;
  assign pop     = rd_en && !empty && !flush;
  assign wr_drop = wr_en && full  && !flush;
  assign rd_drop = rd_en && empty && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= wr_drop;
      underflow <= rd_drop;
      if (flush)                level <= '0;
      else if (push && !pop)    level <= level + CW'(1);
      else if (pop && !push)    level <= level - CW'(1);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush) |=> (overflow && level == $past(level)));
  p_flag_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !$past(wr_en)) |-> 1'b0);
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en && !flush) |=> (underflow && level == '0));
  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (one_entry && !empty && !rd_en) |=> (level <= $past(level)));
  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
endmodule

// File: rtl/byte_queue_req.sv
module byte_queue_req
  import byte_queue_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b0,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          one_entry,
  input  logic [2:0]    trig_sel,
  input  logic [CW-1:0] level,
  input  logic          full,
  input  logic          empty,
  output logic          trig_req,
  output logic          dma_single
);
  logic [CW-1:0] mark;

  assign mark = CW'(trig_thresh(trig_sel, DEPTH, one_entry, IS_TX));
  assign trig_req = trig_hit(IS_TX, int'(level), int'(mark));

  generate
    if (IS_TX) begin : g_tx
      assign dma_single = !full;
      // R11: transmit asks for data whenever room exists
      p_tx_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> dma_single);
      // R9: an empty transmit holding register always triggers
      p_tx_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (one_entry && empty) |-> trig_req);
    end else begin : g_rx
      assign dma_single = !empty;
      // R10: receive asks for service whenever data is held
      p_rx_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> dma_single);
      // R9: a loaded receive holding register always triggers
      p_rx_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (one_entry && full) |-> trig_req);
    end
  endgenerate
endmodule

// File: rtl/byte_queue_dma.sv
module byte_queue_dma #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b0,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          one_entry,
  input  logic [2:0]    trig_sel,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          overflow,
  output logic          underflow,
  output logic          trig_req,
  output logic          dma_single
);
  logic push, pop;

  byte_queue_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .flush(flush), .one_entry(one_entry),
    .wr_en(wr_en), .rd_en(rd_en), .push(push), .pop(pop),
    .level(level), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow)
  );

  byte_queue_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  byte_queue_req #(.DEPTH(DEPTH), .IS_TX(IS_TX)) u_req (
    .clk(clk), .rst_n(rst_n), .one_entry(one_entry), .trig_sel(trig_sel),
    .level(level), .full(full), .empty(empty),
    .trig_req(trig_req), .dma_single(dma_single)
  );

  // R1: an accepted write into an empty queue is visible at the read port next cycle
  p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && push) |=> (rd_data == $past(wr_data)));
endmodule

// File: tb/sim_byte_queue_dma.sv
module sim_byte_queue_dma;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, one_entry = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] trig_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rx_data, tx_data;
  logic [4:0] rx_lvl, tx_lvl;
  logic rx_full, rx_empty, rx_ovf, rx_unf, rx_trig, rx_single;
  logic tx_full, tx_empty, tx_ovf, tx_unf, tx_trig, tx_single;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  byte_queue_dma #(.IS_TX(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .one_entry(one_entry),
    .trig_sel(trig_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rx_data), .level(rx_lvl), .full(rx_full), .empty(rx_empty),
    .overflow(rx_ovf), .underflow(rx_unf), .trig_req(rx_trig), .dma_single(rx_single));

  byte_queue_dma #(.IS_TX(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .one_entry(one_entry),
    .trig_sel(trig_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty),
    .overflow(tx_ovf), .underflow(tx_unf), .trig_req(tx_trig), .dma_single(tx_single));

  // {sel[2:0], fill[4:0], rx_trig, tx_trig}
  localparam logic [9:0] VEC [14] = '{
    {3'd0, 5'd1,  1'b0, 1'b1}, {3'd0, 5'd2,  1'b1, 1'b1},
    {3'd1, 5'd3,  1'b0, 1'b1}, {3'd1, 5'd4,  1'b1, 1'b1},
    {3'd1, 5'd5,  1'b1, 1'b0}, {3'd2, 5'd7,  1'b0, 1'b1},
    {3'd2, 5'd8,  1'b1, 1'b1}, {3'd2, 5'd9,  1'b1, 1'b0},
    {3'd3, 5'd12, 1'b1, 1'b1}, {3'd3, 5'd13, 1'b1, 1'b0},
    {3'd4, 5'd13, 1'b0, 1'b1}, {3'd4, 5'd14, 1'b1, 1'b1},
    {3'd4, 5'd16, 1'b1, 1'b0}, {3'd7, 5'd8,  1'b1, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock with the given strobes; returns 1 time unit after the edge.
  task automatic cyc(input logic w, input logic r, input logic f, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; flush = f; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    check("R12 reset level", rx_lvl, 0);
    check("R12 reset empty", rx_empty, 1);
    check("R12 reset flags", {rx_ovf, rx_unf, tx_ovf, tx_unf}, 0);
    check("R10 rx single empty", rx_single, 0);
    check("R11 tx single empty", tx_single, 1);

    // R6 R7 R8 threshold table
    for (int i = 0; i < 14; i++) begin
      logic [9:0] v;
      v = VEC[i];
      trig_sel = v[9:7];
      cyc(1'b0, 1'b0, 1'b1, 8'h00);
      for (int k = 0; k < int'(v[6:2]); k++) cyc(1'b1, 1'b0, 1'b0, 8'(k));
      check("R2 level", rx_lvl, int'(v[6:2]));
      check("R7 R6 rx trig", rx_trig, int'(v[1]));
      check("R8 R6 tx trig", tx_trig, int'(v[0]));
    end

    // R1 order, R2 full, R3 overflow
    trig_sel = 3'd2;
    cyc(1'b0, 1'b0, 1'b1, 8'h00);
    for (int k = 0; k < 16; k++) cyc(1'b1, 1'b0, 1'b0, 8'(8'hA0 + k));
    check("R2 full", rx_full, 1);
    check("R11 tx single full", tx_single, 0);
    cyc(1'b1, 1'b0, 1'b0, 8'h55);
    check("R3 overflow", rx_ovf, 1);
    check("R3 level held", rx_lvl, 16);
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    check("R3 overflow one cycle", rx_ovf, 0);
    for (int k = 0; k < 16; k++) begin
      check("R1 order", rx_data, 8'hA0 + k);
      cyc(1'b0, 1'b1, 1'b0, 8'h00);
    end
    check("R2 empty", rx_empty, 1);
    check("R10 rx single drained", rx_single, 0);
    // R4 underflow
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    check("R4 underflow", rx_unf, 1);
    check("R4 level held", rx_lvl, 0);
    cyc(1'b0, 1'b0, 1'b0, 8'h00);
    check("R4 underflow one cycle", rx_unf, 0);

    // R5 R9 single-entry mode, selector set to a fractional value
    one_entry = 1'b1; trig_sel = 3'd4;
    #1;
    check("R9 rx trig empty", rx_trig, 0);
    check("R9 tx trig empty", tx_trig, 1);
    cyc(1'b1, 1'b0, 1'b0, 8'h3C);
    check("R5 full at one", rx_full, 1);
    check("R9 rx trig one", rx_trig, 1);
    check("R9 tx trig one", tx_trig, 0);
    check("R11 tx single one", tx_single, 0);
    cyc(1'b1, 1'b0, 1'b0, 8'h77);
    check("R5 second write dropped", rx_lvl, 1);
    check("R5 overflow", tx_ovf, 1);
    check("R1 held byte", rx_data, 8'h3C);
    one_entry = 1'b0;

    // R12 flush wins over a simultaneous write
    cyc(1'b1, 1'b0, 1'b1, 8'h99);
    check("R12 flush level", rx_lvl, 0);
    check("R12 flush no flag", rx_ovf, 0);
    cyc(1'b1, 1'b0, 1'b0, 8'h42);
    check("R12 after flush", rx_data, 8'h42);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule